// File: doc/BRIEF.md
# System Address Range Decoder

This block resolves a physical address to a memory location: the socket that owns it, the memory controller inside that socket and the channel on that controller. Software first loads, per node, a table of range rules, a matching table of interleave-list words and one packed route word, plus the top of low memory and the top of high memory. A request then walks the local node's rule table one entry per clock until a rule claims the address. The rule's interleave granularity picks a 3-bit index from the address, and that index selects a 4-bit target from the rule's interleave word. A target may redirect the search, once, to another node. A local target yields a logical channel, either directly or through a modulo-3 or modulo-2 reduction of the address. The route word maps that logical channel to a controller and a channel index.

Requests enter on a valid/ready port. `req_ready` is high only while the block is idle, so a request waits, with its address held, until the previous result has been taken. The result leaves on a valid/ready port. While `rsp_valid` is high and `rsp_ready` is low, every result field holds still. A new request can be accepted in the cycle after the result handshake.

Top module: `sys_addr_router`

## Requirements
- R1: An address at or above the high-memory top, or at or above the low-memory top and below 4 GiB, completes with code 1 and does not start a rule search.
- R2: A rule word carries: bit 0 enable, bits 2:1 granularity, bits 6:5 mod-2 variant, bits 26:7 limit bits 45:26, bit 27 mod-3 enable, bits 31:30 mod-3 shift code. The inclusive limit has its low 26 bits all ones. Bits 4:3 and 29:28 have no effect.
- R3: Rules are tried in ascending index. Rule i covers the range from one past rule i-1's limit (zero for rule 0) up to its own limit. The bound advances past disabled rules too, and a disabled rule never matches.
- R4: When no rule matches, the result has code 2.
- R5: Granularity 0, 1, 2 or 3 takes the interleave index from address bits 8:6, 10:8, 14:12 or 32:30. The target is bits 4*index+3 : 4*index of the interleave word with the same node and index as the matching rule.
- R6: A target with bit 3 clear redirects to the node named by its bits 2:0. The search restarts at rule 0 of that node's tables and route word. The socket reported is the node that finally resolves the address. Requests start on node 0.
- R7: A redirect found after one redirect has already happened gives code 3. A redirect to a node id of NUM_NODES or more gives code 4.
- R8: With mod-3 disabled, the logical channel is target bits 2:0.
- R9: With mod-3 enabled, v is the address shifted right by 6, 8 or 12 for shift code 0, 1 or 2. A base is formed from v by mod-2 variant: 0 gives v mod 3; 1 gives v mod 2; 2 gives 1 when v is even and 2 when v is odd; 3 gives 2*(v mod 2). The logical channel is 2*base plus target bit 0. Shift code 3 gives code 5.
- R10: The controller index is route-word bits 3L+2:3L and the channel index is bits 18+2L+1:18+2L, where L is the logical channel. Bits beyond 31 read as zero.
- R11: A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is low from then until the result handshake. The result holds while stalled. `rsp_err` is high exactly when the code is non-zero. An error result has socket, controller and channel all zero.
- R12: After reset, `req_ready` is 1 and `rsp_valid` is 0. All tables and both tops are zero, so every address is out of range.
- R13: A configuration write selects its target with `cfg_kind`: 0 rule word, 1 interleave word, 2 route word (uses `cfg_node` only), 3 low-memory top, 4 high-memory top. A top is written as `cfg_wdata[19:0]`, in units of 64 MiB (the address is the value shifted left by 26).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Configuration target select (R13) |
| cfg_node | input | 1 | Node whose table is written |
| cfg_idx | input | 5 | Rule / interleave entry index |
| cfg_wdata | input | 32 | Configuration data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 46 | Physical address to decode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted by consumer |
| rsp_err | output | 1 | Decode failed |
| rsp_code | output | 3 | 0 ok, 1 out of range, 2 no rule, 3 double redirect, 4 bad node, 5 bad mod-3 shift code |
| rsp_socket | output | 3 | Resolving node id |
| rsp_mc | output | 3 | Memory controller index |
| rsp_chan | output | 2 | Channel index |

## Verification
The bench uses a node-0 table whose rules differ one field at a time. A power-of-two rule with every nibble local shows the interleave index directly as the logical channel, so a wrong bit slice shows up as a different controller. The mod-3 rules use each variant and shift code, and an address pair that differs only in the shifted bit separates the variants. Other rules cover a redirect to node 1, a redirect back to node 0 that then redirects again, a redirect to a missing node, and a disabled rule followed by an enabled one, which tests that the lower bound advances past disabled rules. Addresses on both sides of both memory tops check the range filter, and a long spread of addresses checked against a behavioural model gives wide coverage while the result port stalls at irregular times.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int GRAN_LSB = 26;
  localparam int LIM_BITS = 20;
  localparam int ADDR_W   = GRAN_LSB + LIM_BITS;

  typedef enum logic [2:0] {
    CFG_RULE  = 3'd0,
    CFG_ILV   = 3'd1,
    CFG_ROUTE = 3'd2,
    CFG_LOTOP = 3'd3,
    CFG_HITOP = 3'd4
  } cfg_kind_e;

  typedef enum logic [2:0] {
    RC_OK       = 3'd0,
    RC_RANGE    = 3'd1,
    RC_NORULE   = 3'd2,
    RC_DBLHOP   = 3'd3,
    RC_BADNODE  = 3'd4,
    RC_BADSHIFT = 3'd5
  } rc_e;

  typedef struct packed {
    logic [1:0]          shift_code;
    logic                m3_en;
    logic [LIM_BITS-1:0] lim;
    logic [1:0]          m2_var;
    logic [1:0]          gran;
    logic                en;
  } rule_t;

  function automatic rule_t unpack_rule(input logic [31:0] w);
    rule_t r;
    r.en         = w[0];
    r.gran       = w[2:1];
    r.m2_var     = w[6:5];
    r.lim        = w[26:7];
    r.m3_en      = w[27];
    r.shift_code = w[31:30];
    return r;
  endfunction
endpackage

// File: rtl/sar_cfg_store.sv
module sar_cfg_store import sar_pkg::*; #(
  parameter int NUM_NODES = 2,
  parameter int NUM_RULES = 24,
  localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int IDX_W  = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        kind,
  input  logic [NODE_W-1:0] node,
  input  logic [IDX_W-1:0]  idx,
  input  logic [31:0]       wdata,
  input  logic [NODE_W-1:0] rd_node,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rule_word,
  output logic [31:0]       ilv_word,
  output logic [31:0]       route_word,
  output logic [ADDR_W-1:0] lo_top,
  output logic [ADDR_W-1:0] hi_top
);
  logic [31:0]         rule_q  [NUM_NODES][NUM_RULES];
  logic [31:0]         ilv_q   [NUM_NODES][NUM_RULES];
  logic [31:0]         route_q [NUM_NODES];
  logic [LIM_BITS-1:0] lo_q, hi_q;

  logic node_ok, idx_ok;
  assign node_ok = int'(node) < NUM_NODES;
  assign idx_ok  = int'(idx) < NUM_RULES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_NODES; n++) begin
        route_q[n] <= '0;
        for (int i = 0; i < NUM_RULES; i++) begin
          rule_q[n][i] <= '0;
          ilv_q[n][i]  <= '0;
        end
      end
      lo_q <= '0;
      hi_q <= '0;
    end else if (we) begin
      case (cfg_kind_e'(kind))
        CFG_RULE:  if (node_ok && idx_ok) rule_q[node][idx] <= wdata;
        CFG_ILV:   if (node_ok && idx_ok) ilv_q[node][idx]  <= wdata;
        CFG_ROUTE: if (node_ok) route_q[node] <= wdata;
        CFG_LOTOP: lo_q <= wdata[LIM_BITS-1:0];
        CFG_HITOP: hi_q <= wdata[LIM_BITS-1:0];
        default: ;
      endcase
    end
  end

  assign rule_word  = rule_q[rd_node][rd_idx];
  assign ilv_word   = ilv_q[rd_node][rd_idx];
  assign route_word = route_q[rd_node];
  assign lo_top     = {lo_q, {GRAN_LSB{1'b0}}};
  assign hi_top     = {hi_q, {GRAN_LSB{1'b0}}};
endmodule

// File: rtl/sar_chan_pick.sv
module sar_chan_pick import sar_pkg::*; (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       rule_word,
  input  logic [31:0]       ilv_word,
  input  logic [31:0]       route_word,
  output logic              remote,
  output logic [2:0]        remote_id,
  output logic              bad_shift,
  output logic [2:0]        mc,
  output logic [1:0]        chan
);
  rule_t             r;
  logic [2:0]        ilv_idx;
  logic [31:0]       ilv_sh;
  logic [3:0]        tgt;
  logic [ADDR_W-1:0] v, v_mod3;
  logic [1:0]        base;
  logic [2:0]        lchan;
  logic [5:0]        mc_sh, ch_sh;
  logic [31:0]       mc_w, ch_w;

  always_comb begin
    r = unpack_rule(rule_word);
    case (r.gran)
      2'd0:    ilv_idx = addr[8:6];
      2'd1:    ilv_idx = addr[10:8];
      2'd2:    ilv_idx = addr[14:12];
      default: ilv_idx = addr[32:30];
    endcase
    ilv_sh    = ilv_word >> {ilv_idx, 2'b00};
    tgt       = ilv_sh[3:0];
    remote    = !tgt[3];
    remote_id = tgt[2:0];

    case (r.shift_code)
      2'd0:    v = addr >> 6;
      2'd1:    v = addr >> 8;
      2'd2:    v = addr >> 12;
      default: v = addr >> 6;
    endcase
    bad_shift = r.m3_en && (r.shift_code == 2'd3);
    v_mod3    = v % ADDR_W'(3);

    case (r.m2_var)
      2'd0:    base = v_mod3[1:0];
      2'd1:    base = {1'b0, v[0]};
      2'd2:    base = v[0] ? 2'd2 : 2'd1;
      default: base = {v[0], 1'b0};
    endcase
    lchan = r.m3_en ? {base, tgt[0]} : tgt[2:0];

    mc_sh = 6'(lchan) * 6'd3;
    ch_sh = 6'd18 + {2'b00, lchan, 1'b0};
    mc_w  = route_word >> mc_sh;
    ch_w  = route_word >> ch_sh;
    mc    = mc_w[2:0];
    chan  = ch_w[1:0];
  end
endmodule

// File: rtl/sys_addr_router.sv
module sys_addr_router import sar_pkg::*; #(
  parameter int NUM_NODES = 2,
  parameter int NUM_RULES = 24,
  localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int IDX_W  = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [2:0]        rsp_code,
  output logic [2:0]        rsp_socket,
  output logic [2:0]        rsp_mc,
  output logic [1:0]        rsp_chan
);
  localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(64'h1_0000_0000);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_RULES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_PICK, ST_DONE} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NODE_W-1:0] node_q;
  logic              hop_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W:0]   lower_q;
  rc_e               code_q;
  logic [2:0]        sock_q, mc_q;
  logic [1:0]        chan_q;

  logic [31:0]       rule_word, ilv_word, route_word;
  logic [ADDR_W-1:0] lo_top_addr, hi_top_addr;

  sar_cfg_store #(.NUM_NODES(NUM_NODES), .NUM_RULES(NUM_RULES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .kind(cfg_kind), .node(cfg_node), .idx(cfg_idx), .wdata(cfg_wdata),
    .rd_node(node_q), .rd_idx(idx_q),
    .rule_word(rule_word), .ilv_word(ilv_word), .route_word(route_word),
    .lo_top(lo_top_addr), .hi_top(hi_top_addr)
  );

  logic       remote, bad_shift;
  logic [2:0] remote_id, pick_mc;
  logic [1:0] pick_chan;

  sar_chan_pick u_pick (
    .addr(addr_q), .rule_word(rule_word), .ilv_word(ilv_word), .route_word(route_word),
    .remote(remote), .remote_id(remote_id), .bad_shift(bad_shift),
    .mc(pick_mc), .chan(pick_chan)
  );

  rule_t           cur_rule;
  logic [ADDR_W:0] cur_limit;
  logic            rule_hit, out_of_range, take_req;

  always_comb begin
    cur_rule     = unpack_rule(rule_word);
    cur_limit    = {1'b0, cur_rule.lim, {GRAN_LSB{1'b1}}};
    rule_hit     = cur_rule.en && ({1'b0, addr_q} >= lower_q) && ({1'b0, addr_q} <= cur_limit);
    out_of_range = (req_addr >= hi_top_addr) ||
                   ((req_addr >= lo_top_addr) && (req_addr < FOUR_GIB));
    take_req     = req_valid && (st_q == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      node_q  <= '0;
      hop_q   <= 1'b0;
      idx_q   <= '0;
      lower_q <= '0;
      code_q  <= RC_OK;
      sock_q  <= '0;
      mc_q    <= '0;
      chan_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (take_req) begin
          addr_q  <= req_addr;
          node_q  <= '0;
          hop_q   <= 1'b0;
          idx_q   <= '0;
          lower_q <= '0;
          sock_q  <= '0;
          mc_q    <= '0;
          chan_q  <= '0;
          code_q  <= out_of_range ? RC_RANGE : RC_OK;
          st_q    <= out_of_range ? ST_DONE : ST_SCAN;
        end
        ST_SCAN: begin
          if (rule_hit) begin
            st_q <= ST_PICK;
          end else if (idx_q == LAST_IDX) begin
            code_q <= RC_NORULE;
            st_q   <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            lower_q <= cur_limit + 1'b1;
          end
        end
        ST_PICK: begin
          if (remote) begin
            if (hop_q) begin
              code_q <= RC_DBLHOP;
              st_q   <= ST_DONE;
            end else if (int'(remote_id) >= NUM_NODES) begin
              code_q <= RC_BADNODE;
              st_q   <= ST_DONE;
            end else begin
              node_q  <= NODE_W'(remote_id);
              hop_q   <= 1'b1;
              idx_q   <= '0;
              lower_q <= '0;
              st_q    <= ST_SCAN;
            end
          end else if (bad_shift) begin
            code_q <= RC_BADSHIFT;
            st_q   <= ST_DONE;
          end else begin
            sock_q <= 3'(node_q);
            mc_q   <= pick_mc;
            chan_q <= pick_chan;
            st_q   <= ST_DONE;
          end
        end
        default: if (rsp_ready) st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_DONE);
  assign rsp_code   = code_q;
  assign rsp_err    = (code_q != RC_OK);
  assign rsp_socket = sock_q;
  assign rsp_mc     = mc_q;
  assign rsp_chan   = chan_q;
endmodule

// File: rtl/sar_checker.sv
module sar_checker import sar_pkg::*; #(
  parameter int NUM_NODES = 2,
  parameter int NUM_RULES = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [2:0]        rsp_code,
  input logic [2:0]        rsp_socket,
  input logic [2:0]        rsp_mc,
  input logic [1:0]        rsp_chan,
  input logic [ADDR_W-1:0] hi_top
);
  localparam int MAX_BUSY = 2 * (NUM_RULES + 1);

  logic [ADDR_W-1:0] seen_addr;
  logic [15:0]       busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_addr <= '0;
      busy_cnt  <= '0;
    end else begin
      if (req_valid && req_ready) seen_addr <= req_addr;
      if (!req_ready && !rsp_valid) busy_cnt <= busy_cnt + 16'd1;
      else busy_cnt <= '0;
    end
  end

  // R11: never idle and holding a result at once
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R11: result frozen while stalled
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_socket)
                                   && $stable(rsp_mc) && $stable(rsp_chan)));

  // R11: error flag tracks the code
  a_r11_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_err == (rsp_code != 3'd0)));

  // R11: error results carry zero fields
  a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_socket == 3'd0 && rsp_mc == 3'd0 && rsp_chan == 2'd0));

  // R6: resolving node exists
  a_r6_socket_exists: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (int'(rsp_socket) < NUM_NODES));

  // R1: a good decode lies below the high-memory top
  a_r1_ok_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0) |-> (seen_addr < hi_top));

  // R3: at most two full scans plus picks before a result
  a_r3_bounded_scan: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 16'(MAX_BUSY));
endmodule

bind sys_addr_router sar_checker #(.NUM_NODES(NUM_NODES), .NUM_RULES(NUM_RULES)) u_sar_checker (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_code(rsp_code),
  .rsp_socket(rsp_socket), .rsp_mc(rsp_mc), .rsp_chan(rsp_chan),
  .hi_top(hi_top_addr)
);

// File: tb/test_sys_addr_router.sv
module test_sys_addr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_kind = '0;
  logic [0:0]  cfg_node = '0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [45:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_err;
  logic [2:0]  rsp_code, rsp_socket, rsp_mc;
  logic [1:0]  rsp_chan;

  sys_addr_router i_sys_addr_router (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_node(cfg_node), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_code(rsp_code),
    .rsp_socket(rsp_socket), .rsp_mc(rsp_mc), .rsp_chan(rsp_chan)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0] code;
    logic [2:0] sock;
    logic [2:0] mc;
    logic [1:0] ch;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 0;
  bit    mon_on = 0;

  logic [31:0] m_rule [2][24];
  logic [31:0] m_ilv  [2][24];
  logic [31:0] m_route[2];
  logic [19:0] m_lo = '0, m_hi = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_rule(input bit en, input int gran, input int m2,
                                          input bit m3, input int sc, input int lim);
    logic [31:0] w = '0;
    w[0] = en; w[2:1] = 2'(gran); w[6:5] = 2'(m2);
    w[26:7] = 20'(lim); w[27] = m3; w[31:30] = 2'(sc);
    return w;
  endfunction

  function automatic logic [31:0] mk_route(input int node);
    logic [31:0] w = '0;
    for (int l = 0; l < 6; l++) begin
      w[3*l +: 3]    = (node == 0) ? 3'(7 - l) : 3'(l);
      w[18+2*l +: 2] = (node == 0) ? 2'(l) : 2'(3 - (l % 4));
    end
    return w;
  endfunction

  // Behavioural model written from the requirements
  function automatic exp_t model(input logic [45:0] a);
    exp_t e = '0;
    logic [63:0] aa = 64'(a);
    logic [63:0] low, lim, v, rt;
    logic [31:0] w;
    logic [3:0]  t;
    int node = 0, hit, idx, base, l, sh;
    bit hop = 0;
    if (aa >= (64'(m_hi) << 26) || (aa >= (64'(m_lo) << 26) && aa < 64'h1_0000_0000)) begin
      e.code = 3'd1; return e;
    end
    for (int pass = 0; pass < 2; pass++) begin
      hit = -1; low = 0;
      for (int i = 0; i < 24; i++) begin
        w = m_rule[node][i];
        lim = (64'(w[26:7]) << 26) | 64'h3FF_FFFF;
        if (hit < 0) begin
          if (w[0] && aa >= low && aa <= lim) hit = i;
          else low = lim + 1;
        end
      end
      if (hit < 0) begin e.code = 3'd2; return e; end
      w = m_rule[node][hit];
      case (w[2:1])
        2'd0: idx = int'(aa[8:6]);
        2'd1: idx = int'(aa[10:8]);
        2'd2: idx = int'(aa[14:12]);
        default: idx = int'(aa[32:30]);
      endcase
      t = 4'(m_ilv[node][hit] >> (4 * idx));
      if (!t[3]) begin
        if (hop) begin e.code = 3'd3; return e; end
        if (t[2:0] >= 3'd2) begin e.code = 3'd4; return e; end
        node = int'(t[2:0]); hop = 1;
        continue;
      end
      if (w[27]) begin
        if (w[31:30] == 2'd3) begin e.code = 3'd5; return e; end
        sh = (w[31:30] == 2'd0) ? 6 : (w[31:30] == 2'd1) ? 8 : 12;
        v = aa >> sh;
        case (w[6:5])
          2'd0: base = int'(v % 3);
          2'd1: base = int'(v % 2);
          2'd2: base = (v % 2 == 1) ? 2 : 1;
          default: base = int'(v % 2) * 2;
        endcase
        l = base * 2 + int'(t[0]);
      end else begin
        l = int'(t[2:0]);
      end
      rt = 64'(m_route[node]);
      e.mc = 3'(rt >> (3 * l));
      e.ch = 2'(rt >> (18 + 2 * l));
      e.sock = 3'(node);
      return e;
    end
    e.code = 3'd3;
    return e;
  endfunction

  task automatic cfg_write(input int kind, input int node, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_node = 1'(node); cfg_idx = 5'(idx); cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    case (kind)
      0: m_rule[node][idx] = d;
      1: m_ilv[node][idx] = d;
      2: m_route[node] = d;
      3: m_lo = d[19:0];
      default: m_hi = d[19:0];
    endcase
  endtask

  // Driver: offers one address, pushes its expected result on acceptance
  task automatic send(input logic [45:0] a, input string tag);
    bit taken;
    exp_t e;
    e = model(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    taken = 0;
    while (!taken) begin
      taken = req_ready;
      @(posedge clk);
      if (taken) begin exp_q.push_back(e); tag_q.push_back(tag); end
      else @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R11", "req_ready after accept", req_ready, 0);
  endtask

  // Monitor: irregular back-pressure, compares results as they are consumed
  int   mon_cyc = 0;
  bit   prev_stall = 0;
  exp_t prev_seen;
  always @(negedge clk) begin
    exp_t got, e;
    string tg;
    if (mon_on) begin
      got = {rsp_code, rsp_socket, rsp_mc, rsp_chan};
      if (prev_stall)
        check(rsp_valid && got == prev_seen, "R11", "stalled result held", got, prev_seen);
      mon_cyc++;
      rsp_ready = !((mon_cyc % 7 == 3) || (mon_cyc % 11 == 5) || (mon_cyc % 11 == 6));
      prev_stall = rsp_valid && !rsp_ready;
      prev_seen = got;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected result", got, 0);
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(got == e, tg, "result {code,socket,mc,chan}", got, e);
          check(rsp_err == (e.code != 3'd0), tg, "rsp_err", rsp_err, e.code != 3'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a64;
    for (int n = 0; n < 2; n++) begin
      m_route[n] = '0;
      for (int i = 0; i < 24; i++) begin m_rule[n][i] = '0; m_ilv[n][i] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R12", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);
    mon_on = 1;
    send(46'h1000, "R12");

    // Node 0 rules (limits in 64 MiB units)
    cfg_write(0, 0, 0,  mk_rule(1, 0, 0, 0, 0, 31));
    cfg_write(1, 0, 0,  32'hFEDC_BA98);
    cfg_write(0, 0, 1,  mk_rule(0, 0, 0, 0, 0, 63) | 32'h3000_0018);
    cfg_write(0, 0, 2,  mk_rule(1, 3, 0, 1, 1, 95));
    cfg_write(1, 0, 2,  32'h0019_0000);
    cfg_write(0, 0, 3,  mk_rule(1, 1, 2, 1, 2, 111));
    cfg_write(1, 0, 3,  32'h8888_8888);
    cfg_write(0, 0, 4,  mk_rule(1, 2, 0, 1, 3, 119));
    cfg_write(1, 0, 4,  32'h8888_8888);
    cfg_write(0, 0, 5,  mk_rule(1, 0, 3, 1, 0, 123));
    cfg_write(1, 0, 5,  32'h9999_9999);
    cfg_write(0, 0, 6,  mk_rule(1, 2, 1, 1, 0, 125));
    cfg_write(1, 0, 6,  32'hF8F8_F8F8);
    cfg_write(0, 0, 7,  mk_rule(1, 0, 0, 0, 0, 126));
    cfg_write(1, 0, 7,  32'h2222_2222);
    cfg_write(0, 0, 8,  mk_rule(1, 0, 0, 0, 0, 127));
    cfg_write(1, 0, 8,  32'h0000_0000);
    cfg_write(0, 0, 9,  mk_rule(0, 0, 0, 0, 0, 128));
    cfg_write(1, 0, 9,  32'h8888_8888);
    cfg_write(0, 0, 10, mk_rule(1, 0, 0, 0, 0, 129));
    cfg_write(1, 0, 10, 32'h8888_8888);
    cfg_write(2, 0, 0,  mk_route(0));
    // Node 1
    cfg_write(0, 1, 0,  mk_rule(0, 0, 0, 0, 0, 79));
    cfg_write(0, 1, 1,  mk_rule(1, 0, 0, 0, 0, 127));
    cfg_write(1, 1, 1,  32'hBBBB_BBBB);
    cfg_write(2, 1, 0,  mk_route(1));
    // Tops: 2 GiB and 130 * 64 MiB
    cfg_write(3, 0, 0,  32'd32);
    cfg_write(4, 0, 0,  32'd130);

    send(46'h0_7FFF_FFFF, "R1");
    send(46'h0_8000_0000, "R1");
    send(46'h0_FFFF_FFFF, "R1");
    send(46'h0_0000_0040, "R8");
    send(46'h0_0000_01C0, "R10");
    send(46'h0_0000_0140, "R5");
    send(46'h1_0000_0000, "R2");
    send(46'h1_0000_0100, "R9");
    send(46'h1_0000_0200, "R9");
    send(46'h1_4000_0040, "R6");
    send(46'h1_8000_0000, "R9");
    send(46'h1_8000_1000, "R9");
    send(46'h1_C000_0000, "R9");
    send(46'h1_E000_0000, "R9");
    send(46'h1_E000_0040, "R9");
    send(46'h1_F000_1000, "R5");
    send(46'h1_F000_0040, "R9");
    send(46'h1_F800_0000, "R7");
    send(46'h1_FC00_0000, "R7");
    send(46'h2_0000_0000, "R4");
    send(46'h2_0400_0000, "R3");
    send(46'h2_07FF_FFFF, "R13");
    send(46'h2_0800_0000, "R13");

    for (int k = 0; k < 160; k++) begin
      a64 = (64'(k) * 64'h3_1F0B_2C7 + 64'h155) % (64'd131 << 26);
      send(46'(a64), "R5");
    end

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    check(exp_q.size() == 0, "R11", "all results delivered", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule